// File: doc/BRIEF.md
# Descriptor-Driven Word Copy Channel with Fault Lock

This block is one copy engine. Software loads a source address, a destination address, a byte count and two attribute bits through a small register port, then writes a start bit. The channel moves 32-bit words. For each word it reads from the source over a read port and writes the word to the destination over a write port. Each attribute bit pins one side's address in place. A pinned source can fill a region with a single value. A pinned destination can drain a buffer into a single location.

Errors are reported in a shared flag register. A read-side or write-side error response stops the channel and locks it. The lock survives clearing the flag, and only a reinitialise command lifts it. A byte count too small to hold one word raises a separate flag. That flag does not identify which channel caused it. It does not lock anything, and the channel stays marked busy until it is restarted or reinitialised.

Top module: `dmach_top`

## Requirements
- R1: A control write (register index 0) with bit 0 set starts the channel when it is not mid-transfer and not locked. The busy bit reads 1 and the read request is raised in the cycle after the write.
- R2: Each beat reads one 32-bit word from the source on the read port and writes that same word to the destination on the write port. The beat count is the byte count (index 3) shifted right by two, so the two low bits are ignored.
- R3: Each address advances by 4 after every completed beat. An address stays fixed when its attribute bit is set (index 4: bit 0 for the source, bit 1 for the destination).
- R4: The busy bit clears in the cycle after the final error-free write handshake.
- R5: An error response on the read port sets error bit 0, and one on the write port sets error bit 1 (index 5). Either error locks the channel, leaves busy set, and removes all requests.
- R6: While the channel is locked, a start write has no effect, even after the error bits have been cleared.
- R7: A control write with bit 1 set reinitialises the channel. It clears the lock and busy, and drops any outstanding request, in the next cycle. The error bits are left unchanged.
- R8: A start with a byte count below 4 sets error bit 2, issues no memory request, and leaves busy set without locking. A later start with a valid count runs normally.
- R9: Error bits are write-one-to-clear, and writing a 0 leaves a bit unchanged. An error bit falls only after such a clearing write.
- R10: Register reads return data one cycle after the index is presented. Index 0 reads busy in bit 0 and lock in bit 1. Indices 1 to 4 read back the descriptor fields.
- R11: Descriptor writes made during a transfer do not alter the transfer already running.
- R12: After reset every output, error bit and register reads 0, and at most one port requests at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | RA_W | Register word index |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data for reg_addr |
| a_valid | output | 1 | Read request |
| a_addr | output | ADDR_W | Read address |
| a_ready | input | 1 | Read accepted, data and error valid |
| a_rdata | input | DATA_W | Read data |
| a_err | input | 1 | Read error response |
| b_valid | output | 1 | Write request |
| b_addr | output | ADDR_W | Write address |
| b_wdata | output | DATA_W | Write data |
| b_ready | input | 1 | Write accepted, error valid |
| b_err | input | 1 | Write error response |
| active_o | output | 1 | Channel busy |
| frozen_o | output | 1 | Channel locked by a port error |
| err_o | output | 3 | Error flags: read, write, short count |

## Verification
The hardest state to reach from the ports is a locked channel whose error flags have already been cleared. It must then refuse a fresh start until it is reinitialised. The bench gets there by giving the read or write responder an error at one chosen address in the middle of a multi-word transfer. It then clears the flag through the register port and issues another start, while a reference model flags any request that appears. A reinitialise issued in the middle of a transfer, and descriptor rewrites made while beats are in flight, are driven the same way, with the ready signals toggling pseudo-randomly.

// File: rtl/dmach_pkg.sv
`timescale 1ns/1ps
package dmach_pkg;
  localparam int REG_CTRL = 0;
  localparam int REG_SRC  = 1;
  localparam int REG_DST  = 2;
  localparam int REG_SIZE = 3;
  localparam int REG_ATTR = 4;
  localparam int REG_ERR  = 5;
  localparam int NUM_REGS = 6;

  localparam int CTRL_GO_BIT     = 0;
  localparam int CTRL_REINIT_BIT = 1;
  localparam int ERR_W           = 3;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_RD   = 2'd1,
    ENG_WR   = 2'd2
  } eng_state_e;

  // field order matches the error register bits (msb first)
  typedef struct packed {
    logic size0;
    logic port_b;
    logic port_a;
  } err_ev_t;
endpackage

// File: rtl/dmach_regs.sv
`timescale 1ns/1ps
module dmach_regs
  import dmach_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 16,
  parameter int RA_W   = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_wr_en,
  input  logic [RA_W-1:0]      reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  input  logic                 active,
  input  logic                 frozen,
  input  err_ev_t              ev,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic [ADDR_W-1:0]    src_q,
  output logic [ADDR_W-1:0]    dst_q,
  output logic [SIZE_W-3:0]    size_words,
  output logic                 fix_src_q,
  output logic                 fix_dst_q,
  output logic                 go,
  output logic                 reinit,
  output logic [ERR_W-1:0]     err_q
);
  localparam int LSB = 2;

  logic [NUM_REGS-1:0] wr_sel;
  logic [SIZE_W-1:0]   size_q;
  logic [DATA_W-1:0]   rd_next;
  logic [ERR_W-1:0]    ev_bits;
  logic [ERR_W-1:0]    w1c;

  generate
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
      assign wr_sel[i] = reg_wr_en && (reg_addr == RA_W'(i));
    end
  endgenerate

  assign go         = wr_sel[REG_CTRL] && reg_wdata[CTRL_GO_BIT];
  assign reinit     = wr_sel[REG_CTRL] && reg_wdata[CTRL_REINIT_BIT];
  assign size_words = size_q[SIZE_W-1:LSB];
  assign ev_bits    = {ev.size0, ev.port_b, ev.port_a};
  assign w1c        = wr_sel[REG_ERR] ? reg_wdata[ERR_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q     <= '0;
      dst_q     <= '0;
      size_q    <= '0;
      fix_src_q <= 1'b0;
      fix_dst_q <= 1'b0;
      err_q     <= '0;
    end else begin
      if (wr_sel[REG_SRC])  src_q  <= reg_wdata[ADDR_W-1:0];
      if (wr_sel[REG_DST])  dst_q  <= reg_wdata[ADDR_W-1:0];
      if (wr_sel[REG_SIZE]) size_q <= reg_wdata[SIZE_W-1:0];
      if (wr_sel[REG_ATTR]) begin
        fix_src_q <= reg_wdata[0];
        fix_dst_q <= reg_wdata[1];
      end
      // a new event wins over a clear in the same cycle
      err_q <= (err_q & ~w1c) | ev_bits;
    end
  end

  always_comb begin
    rd_next = '0;
    case (reg_addr)
      RA_W'(REG_CTRL): rd_next[1:0]         = {frozen, active};
      RA_W'(REG_SRC):  rd_next[ADDR_W-1:0]  = src_q;
      RA_W'(REG_DST):  rd_next[ADDR_W-1:0]  = dst_q;
      RA_W'(REG_SIZE): rd_next[SIZE_W-1:0]  = size_q;
      RA_W'(REG_ATTR): rd_next[1:0]         = {fix_dst_q, fix_src_q};
      RA_W'(REG_ERR):  rd_next[ERR_W-1:0]   = err_q;
      default:         rd_next              = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_next;
  end
endmodule

// File: rtl/dmach_addr_step.sv
`timescale 1ns/1ps
module dmach_addr_step #(
  parameter int ADDR_W = 32,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic              fixed_in,
  input  logic              advance,
  output logic [ADDR_W-1:0] addr_q
);
  logic fixed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      fixed_q <= 1'b0;
    end else if (load) begin
      addr_q  <= base;
      fixed_q <= fixed_in;
    end else if (advance && !fixed_q) begin
      addr_q  <= addr_q + ADDR_W'(STEP);
    end
  end
endmodule

// File: rtl/dmach_engine.sv
`timescale 1ns/1ps
module dmach_engine
  import dmach_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              reinit,
  input  logic [CNT_W-1:0]  words,
  input  logic              a_ready,
  input  logic [DATA_W-1:0] a_rdata,
  input  logic              a_err,
  input  logic              b_ready,
  input  logic              b_err,
  output logic              a_valid,
  output logic              b_valid,
  output logic [DATA_W-1:0] b_wdata,
  output logic              load,
  output logic              advance,
  output logic              active,
  output logic              frozen,
  output err_ev_t           ev
);
  eng_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] data_q;
  logic              start_ok;
  logic              zero_len;
  logic              last_beat;

  assign zero_len  = (words == '0);
  assign start_ok  = go && !reinit && !frozen && (state_q == ENG_IDLE);
  assign last_beat = (cnt_q == CNT_W'(1));
  assign load      = start_ok && !zero_len;
  assign advance   = (state_q == ENG_WR) && b_ready && !b_err && !reinit;
  assign b_wdata   = data_q;

  always_comb begin
    ev.size0  = start_ok && zero_len;
    ev.port_a = (state_q == ENG_RD) && a_ready && a_err && !reinit;
    ev.port_b = (state_q == ENG_WR) && b_ready && b_err && !reinit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ENG_IDLE;
      a_valid <= 1'b0;
      b_valid <= 1'b0;
      active  <= 1'b0;
      frozen  <= 1'b0;
      cnt_q   <= '0;
      data_q  <= '0;
    end else if (reinit) begin
      state_q <= ENG_IDLE;
      a_valid <= 1'b0;
      b_valid <= 1'b0;
      active  <= 1'b0;
      frozen  <= 1'b0;
    end else begin
      unique case (state_q)
        ENG_IDLE: begin
          if (start_ok) begin
            active <= 1'b1;
            if (!zero_len) begin
              cnt_q   <= words;
              a_valid <= 1'b1;
              state_q <= ENG_RD;
            end
          end
        end
        ENG_RD: begin
          if (a_ready) begin
            a_valid <= 1'b0;
            if (a_err) begin
              frozen  <= 1'b1;
              state_q <= ENG_IDLE;
            end else begin
              data_q  <= a_rdata;
              b_valid <= 1'b1;
              state_q <= ENG_WR;
            end
          end
        end
        ENG_WR: begin
          if (b_ready) begin
            b_valid <= 1'b0;
            if (b_err) begin
              frozen  <= 1'b1;
              state_q <= ENG_IDLE;
            end else if (last_beat) begin
              active  <= 1'b0;
              state_q <= ENG_IDLE;
            end else begin
              cnt_q   <= cnt_q - CNT_W'(1);
              a_valid <= 1'b1;
              state_q <= ENG_RD;
            end
          end
        end
        default: state_q <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dmach_top.sv
`timescale 1ns/1ps
module dmach_top
  import dmach_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 16,
  parameter int RA_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              a_valid,
  output logic [ADDR_W-1:0] a_addr,
  input  logic              a_ready,
  input  logic [DATA_W-1:0] a_rdata,
  input  logic              a_err,
  output logic              b_valid,
  output logic [ADDR_W-1:0] b_addr,
  output logic [DATA_W-1:0] b_wdata,
  input  logic              b_ready,
  input  logic              b_err,
  output logic              active_o,
  output logic              frozen_o,
  output logic [2:0]        err_o
);
  localparam int STEP  = DATA_W / 8;
  localparam int CNT_W = SIZE_W - 2;

  logic [ADDR_W-1:0] src_q, dst_q;
  logic [CNT_W-1:0]  size_words;
  logic              fix_src_q, fix_dst_q;
  logic              go, reinit, load, advance;
  logic [ERR_W-1:0]  err_q;
  err_ev_t           ev;

  logic [ADDR_W-1:0] side_base [2];
  logic [ADDR_W-1:0] side_addr [2];
  logic              side_fix  [2];

  dmach_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .RA_W(RA_W)
  ) u_regs (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .active(active_o), .frozen(frozen_o), .ev(ev),
    .reg_rdata(reg_rdata), .src_q(src_q), .dst_q(dst_q),
    .size_words(size_words), .fix_src_q(fix_src_q), .fix_dst_q(fix_dst_q),
    .go(go), .reinit(reinit), .err_q(err_q)
  );

  dmach_engine #(
    .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) u_engine (
    .clk(clk), .rst(rst), .go(go), .reinit(reinit), .words(size_words),
    .a_ready(a_ready), .a_rdata(a_rdata), .a_err(a_err),
    .b_ready(b_ready), .b_err(b_err),
    .a_valid(a_valid), .b_valid(b_valid), .b_wdata(b_wdata),
    .load(load), .advance(advance), .active(active_o), .frozen(frozen_o),
    .ev(ev)
  );

  assign side_base[0] = src_q;
  assign side_base[1] = dst_q;
  assign side_fix[0]  = fix_src_q;
  assign side_fix[1]  = fix_dst_q;

  generate
    for (genvar s = 0; s < 2; s++) begin : g_side
      dmach_addr_step #(
        .ADDR_W(ADDR_W), .STEP(STEP)
      ) u_step (
        .clk(clk), .rst(rst), .load(load), .base(side_base[s]),
        .fixed_in(side_fix[s]), .advance(advance), .addr_q(side_addr[s])
      );
    end
  endgenerate

  assign a_addr = side_addr[0];
  assign b_addr = side_addr[1];
  assign err_o  = err_q;
endmodule

// File: rtl/dmach_checker.sv
`timescale 1ns/1ps
module dmach_checker
  import dmach_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int RA_W   = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr_en,
  input logic [RA_W-1:0]   reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              a_valid,
  input logic [ADDR_W-1:0] a_addr,
  input logic              a_ready,
  input logic              a_err,
  input logic              b_valid,
  input logic [ADDR_W-1:0] b_addr,
  input logic [DATA_W-1:0] b_wdata,
  input logic              b_ready,
  input logic              b_err,
  input logic              active_o,
  input logic              frozen_o,
  input logic [2:0]        err_o
);
  logic reinit_wr, errw;
  assign reinit_wr = reg_wr_en && (reg_addr == RA_W'(REG_CTRL)) && reg_wdata[CTRL_REINIT_BIT];
  assign errw      = reg_wr_en && (reg_addr == RA_W'(REG_ERR));

  a_r12_single_port: assert property (@(posedge clk) disable iff (rst)
    !(a_valid && b_valid));

  a_r1_req_needs_busy: assert property (@(posedge clk) disable iff (rst)
    (a_valid || b_valid) |-> active_o);

  a_r2_read_hold: assert property (@(posedge clk) disable iff (rst)
    (a_valid && !a_ready && !reinit_wr) |=> (a_valid && $stable(a_addr)));

  a_r2_write_hold: assert property (@(posedge clk) disable iff (rst)
    (b_valid && !b_ready && !reinit_wr) |=> (b_valid && $stable(b_addr) && $stable(b_wdata)));

  a_r5_read_err_locks: assert property (@(posedge clk) disable iff (rst)
    (a_valid && a_ready && a_err && !reinit_wr) |=> (err_o[0] && frozen_o && active_o));

  a_r5_write_err_locks: assert property (@(posedge clk) disable iff (rst)
    (b_valid && b_ready && b_err && !reinit_wr) |=> (err_o[1] && frozen_o && active_o));

  a_r6_locked_quiet: assert property (@(posedge clk) disable iff (rst)
    frozen_o |-> (!a_valid && !b_valid));

  a_r7_reinit_clears: assert property (@(posedge clk) disable iff (rst)
    reinit_wr |=> (!active_o && !frozen_o && !a_valid && !b_valid));

  a_r4_busy_drop_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(active_o) |-> $past(reinit_wr || (b_valid && b_ready && !b_err)));

  a_r9_clear_a: assert property (@(posedge clk) disable iff (rst)
    $fell(err_o[0]) |-> $past(errw && reg_wdata[0]));

  a_r9_clear_b: assert property (@(posedge clk) disable iff (rst)
    $fell(err_o[1]) |-> $past(errw && reg_wdata[1]));

  a_r9_clear_sz: assert property (@(posedge clk) disable iff (rst)
    $fell(err_o[2]) |-> $past(errw && reg_wdata[2]));
endmodule

bind dmach_top dmach_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .RA_W(RA_W)
) u_chk (.*);

// File: tb/dmach_top_tb_top.sv
`timescale 1ns/1ps
module dmach_top_tb_top;
  localparam int DW = 32, AW = 32, SW = 16, RAW = 3;
  localparam logic [31:0] BASE = 32'hA500_0000;

  logic clk = 1'b0, rst = 1'b1;
  always #2.5 clk = ~clk;

  logic           reg_wr_en = 1'b0;
  logic [RAW-1:0] reg_addr  = '0;
  logic [DW-1:0]  reg_wdata = '0;
  logic [DW-1:0]  reg_rdata;
  logic a_valid, a_ready = 1'b0, a_err, b_valid, b_ready = 1'b0, b_err;
  logic [AW-1:0] a_addr, b_addr;
  logic [DW-1:0] a_rdata, b_wdata;
  logic active_o, frozen_o;
  logic [2:0] err_o;

  logic [31:0] mem [256];
  logic inj_a_en = 1'b0, inj_b_en = 1'b0;
  logic [31:0] inj_a_addr = '0, inj_b_addr = '0;

  assign a_rdata = mem[a_addr[9:2]];
  assign a_err   = inj_a_en && a_valid && (a_addr == inj_a_addr);
  assign b_err   = inj_b_en && b_valid && (b_addr == inj_b_addr);

  dmach_top #(.DATA_W(DW), .ADDR_W(AW), .SIZE_W(SW), .RA_W(RAW)) dut_i (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .a_valid(a_valid), .a_addr(a_addr), .a_ready(a_ready), .a_rdata(a_rdata), .a_err(a_err),
    .b_valid(b_valid), .b_addr(b_addr), .b_wdata(b_wdata), .b_ready(b_ready), .b_err(b_err),
    .active_o(active_o), .frozen_o(frozen_o), .err_o(err_o));

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic end_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // ---------------- reference model ----------------
  logic        exp_active = 1'b0, exp_frozen = 1'b0;
  logic [2:0]  exp_err = '0;
  logic [31:0] m_src = '0, m_dst = '0;
  logic [15:0] m_size = '0;
  logic [1:0]  m_attr = '0;
  logic [31:0] rdq[$], wraq[$], wrdq[$];
  logic [15:0] lfsr = 16'hACE1;

  always @(negedge clk) begin
    if (rst) begin
      a_ready = 1'b0;
      b_ready = 1'b0;
    end else begin
      logic [2:0] setb, w1c;
      bit was_idle;
      int words;
      chk(active_o == exp_active, "R4 busy bit", 32'(active_o), 32'(exp_active));
      chk(frozen_o == exp_frozen, "R6 lock bit", 32'(frozen_o), 32'(exp_frozen));
      chk(err_o == exp_err, "R9 error flags", 32'(err_o), 32'(exp_err));
      if (a_valid) chk(rdq.size() != 0, "R5 stray read request", a_addr, 0);
      if (b_valid) chk(wraq.size() != 0, "R5 stray write request", b_addr, 0);

      lfsr    = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a_ready = lfsr[0] | lfsr[2];
      b_ready = lfsr[4] | lfsr[7];

      setb     = '0;
      was_idle = (wraq.size() == 0);
      if (a_valid && a_ready) begin
        if (rdq.size() > 0) begin
          chk(a_addr == rdq[0], "R3 source address", a_addr, rdq[0]);
          void'(rdq.pop_front());
        end
        if (a_err) begin
          setb[0] = 1'b1; exp_frozen = 1'b1;
          rdq.delete(); wraq.delete(); wrdq.delete();
        end else wrdq.push_back(a_rdata);
      end
      if (b_valid && b_ready) begin
        if (wraq.size() > 0) begin
          chk(b_addr == wraq[0], "R3 destination address", b_addr, wraq[0]);
          if (wrdq.size() > 0) begin
            chk(b_wdata == wrdq[0], "R2 copied word", b_wdata, wrdq[0]);
            void'(wrdq.pop_front());
          end
          void'(wraq.pop_front());
        end
        if (b_err) begin
          setb[1] = 1'b1; exp_frozen = 1'b1;
          rdq.delete(); wraq.delete(); wrdq.delete();
        end else begin
          mem[b_addr[9:2]] = b_wdata;
          if (wraq.size() == 0) exp_active = 1'b0;
        end
      end
      if (reg_wr_en && reg_addr == 0 && reg_wdata[1]) begin
        exp_active = 1'b0; exp_frozen = 1'b0; setb = '0;
        rdq.delete(); wraq.delete(); wrdq.delete();
      end else if (reg_wr_en && reg_addr == 0 && reg_wdata[0] && was_idle && !exp_frozen) begin
        exp_active = 1'b1;
        words = int'(m_size >> 2);
        if (words == 0) setb[2] = 1'b1;
        for (int k = 0; k < words; k++) begin
          rdq.push_back(m_src + (m_attr[0] ? 32'd0 : 32'(4 * k)));
          wraq.push_back(m_dst + (m_attr[1] ? 32'd0 : 32'(4 * k)));
        end
      end
      w1c     = (reg_wr_en && reg_addr == 5) ? reg_wdata[2:0] : 3'b000;
      exp_err = (exp_err & ~w1c) | setb;
      if (reg_wr_en) begin
        case (reg_addr)
          3'd1: m_src  = reg_wdata;
          3'd2: m_dst  = reg_wdata;
          3'd3: m_size = reg_wdata[15:0];
          3'd4: m_attr = reg_wdata[1:0];
          default: ;
        endcase
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input int idx, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr_en = 1'b1; reg_addr = RAW'(idx); reg_wdata = d;
    @(posedge clk); #1;
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [31:0] d);
    @(posedge clk); #1;
    reg_addr = RAW'(idx);
    @(posedge clk); #1;
    d = reg_rdata;
  endtask

  task automatic desc(input logic [31:0] s, input logic [31:0] dd, input logic [31:0] sz, input logic [31:0] at);
    wr(1, s); wr(2, dd); wr(3, sz); wr(4, at);
  endtask

  task automatic wait_done();
    @(negedge clk);
    for (int i = 0; i < 2000 && active_o; i++) @(negedge clk);
    repeat (2) @(posedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    end_run();
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 256; i++) mem[i] = BASE + 32'(i);
    repeat (4) @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    chk(!a_valid && !b_valid && !active_o && !frozen_o && err_o == 0, "R12 reset outputs",
        {a_valid, b_valid, active_o, frozen_o, err_o}, 0);
    rd(5, v); chk(v == 0, "R12 error register after reset", v, 0);
    rd(1, v); chk(v == 0, "R12 source register after reset", v, 0);

    // plain copy, count 18 bytes -> 4 words
    desc(32'h100, 32'h200, 32'd18, 0);
    wr(0, 32'h1);
    @(negedge clk);
    chk(active_o && a_valid, "R1 start raises busy and read request", {active_o, a_valid}, 32'h3);
    wait_done();
    for (int k = 0; k < 4; k++) chk(mem[128+k] == BASE + 32'(64+k), "R2 destination word", mem[128+k], BASE + 32'(64+k));
    chk(mem[132] == BASE + 32'd132, "R2 low count bits ignored", mem[132], BASE + 32'd132);
    rd(0, v); chk(v == 0, "R4 busy clear after completion", v, 0);
    rd(1, v); chk(v == 32'h100, "R10 source readback", v, 32'h100);
    rd(3, v); chk(v == 32'd18, "R10 count readback", v, 32'd18);

    // fixed source fill
    desc(32'h300, 32'h280, 32'd12, 32'h1);
    wr(0, 32'h1); wait_done();
    for (int k = 0; k < 3; k++) chk(mem[160+k] == BASE + 32'd192, "R3 fixed source fill", mem[160+k], BASE + 32'd192);
    chk(mem[163] == BASE + 32'd163, "R3 fill stops at count", mem[163], BASE + 32'd163);

    // fixed destination drain
    desc(32'h040, 32'h3F0, 32'd16, 32'h2);
    wr(0, 32'h1); wait_done();
    chk(mem[252] == BASE + 32'd19, "R3 fixed destination keeps last word", mem[252], BASE + 32'd19);
    chk(mem[253] == BASE + 32'd253, "R3 fixed destination neighbour untouched", mem[253], BASE + 32'd253);

    // short count
    wr(3, 32'd2); wr(0, 32'h1);
    repeat (4) @(posedge clk);
    rd(5, v); chk(v == 32'h4, "R8 short count flag", v, 32'h4);
    rd(0, v); chk(v == 32'h1, "R8 busy kept, not locked", v, 32'h1);
    wr(5, 32'h0);
    rd(5, v); chk(v == 32'h4, "R9 writing zero keeps flag", v, 32'h4);
    wr(5, 32'h4);
    rd(5, v); chk(v == 32'h0, "R9 write one clears flag", v, 0);
    desc(32'h000, 32'h380, 32'd8, 0);
    wr(0, 32'h1); wait_done();
    chk(mem[224] == BASE && mem[225] == BASE + 32'd1, "R8 restart after short count", mem[225], BASE + 32'd1);

    // read-port error
    inj_a_en = 1'b1; inj_a_addr = 32'h144;
    desc(32'h140, 32'h2C0, 32'd16, 0);
    wr(0, 32'h1);
    repeat (40) @(posedge clk);
    rd(0, v); chk(v == 32'h3, "R5 locked with busy set", v, 32'h3);
    rd(5, v); chk(v == 32'h1, "R5 read error flag", v, 32'h1);
    chk(mem[176] == BASE + 32'd80, "R5 beat before error written", mem[176], BASE + 32'd80);
    chk(mem[177] == BASE + 32'd177, "R5 no write after error", mem[177], BASE + 32'd177);
    inj_a_en = 1'b0;
    wr(5, 32'h1);
    wr(0, 32'h1);
    repeat (20) @(posedge clk);
    rd(0, v); chk(v == 32'h3, "R6 start ignored while locked", v, 32'h3);
    wr(0, 32'h2);
    rd(0, v); chk(v == 32'h0, "R7 reinit clears lock and busy", v, 0);

    // write-port error, reinit without clearing
    inj_b_en = 1'b1; inj_b_addr = 32'h304;
    desc(32'h180, 32'h300, 32'd8, 0);
    wr(0, 32'h1);
    repeat (40) @(posedge clk);
    rd(5, v); chk(v == 32'h2, "R5 write error flag", v, 32'h2);
    chk(mem[192] == BASE + 32'd96, "R5 first write landed", mem[192], BASE + 32'd96);
    inj_b_en = 1'b0;
    wr(0, 32'h2);
    rd(0, v); chk(v == 32'h0, "R7 reinit unlocks", v, 0);
    rd(5, v); chk(v == 32'h2, "R7 reinit keeps error flags", v, 32'h2);
    wr(5, 32'h2);

    // descriptor rewrite during transfer
    desc(32'h0C0, 32'h340, 32'd32, 0);
    wr(0, 32'h1);
    repeat (3) @(posedge clk);
    wr(1, 32'h0); wr(2, 32'h0); wr(3, 32'd4);
    wait_done();
    for (int k = 0; k < 8; k++) chk(mem[208+k] == BASE + 32'(48+k), "R11 running transfer unaffected", mem[208+k], BASE + 32'(48+k));

    // reinit in mid-transfer
    desc(32'h000, 32'h3C0, 32'd64, 0);
    wr(0, 32'h1);
    repeat (6) @(posedge clk);
    wr(0, 32'h2);
    repeat (10) @(posedge clk);
    rd(0, v); chk(v == 32'h0, "R7 reinit aborts transfer", v, 0);
    rd(5, v); chk(v == 32'h0, "R7 abort raises no flag", v, 0);

    repeat (5) @(posedge clk);
    end_run();
  end
endmodule